// File: doc/BRIEF.md
# Bridge Data Parity Error Status Logic

This block tracks data parity errors for a two-port bridge that joins a primary bus and a secondary bus. It keeps one sticky "master saw a data parity error" flag per interface, and it produces the active-low parity error drive on the primary bus. A bus flag can only be set when the bridge is the master on that bus. Which bus the bridge masters follows from the transfer direction: upstream transfers are mastered on the primary side and downstream transfers on the secondary side. Each flag is also gated by the parity error response enable of its own interface.

The primary parity error drive belongs to the transfers where the bridge receives data on the primary bus. These are downstream writes, where the bridge is the target, and upstream reads, where the bridge is the initiator. For these transfers the drive goes low two clocks after the failing data phase and stays low for one clock. Software clears each flag by writing a 1 to its bit position.

Top module: `bridge_perr_status`

## Requirements
- R1: With `xfer_vld`=1, `dir_up`=1 and `pri_resp_en`=1, either `pri_perr_det`=1 or `pri_perr_in_n`=0 sets `pri_mdpe` at the next clock edge. This holds for every `txn_kind` (0 read, 1 posted write, 2 delayed write). Nothing sets a flag while `xfer_vld`=0.
- R2: With `pri_resp_en`=0, `pri_mdpe` is never set. `sec_resp_en` has no effect on `pri_mdpe`.
- R3: With `xfer_vld`=1, `dir_up`=0 and `sec_resp_en`=1, either `sec_perr_det`=1 or `sec_perr_in_n`=0 sets `sec_mdpe` at the next edge. With `sec_resp_en`=0 it is never set, and `pri_resp_en` has no effect on it.
- R4: Errors seen on the wrong side are ignored. Primary-side errors during downstream transfers leave `pri_mdpe` at 0. Secondary-side errors during upstream transfers leave `sec_mdpe` at 0.
- R5: Both flags hold until cleared. A cycle with `stat_wr`=1 clears `pri_mdpe` when `stat_wdata[0]`=1 and clears `sec_mdpe` when `stat_wdata[1]`=1. A 0 in a data bit leaves that flag unchanged.
- R6: When a set condition and a clear for the same flag occur in the same cycle, the flag ends up set.
- R7: `pri_perr_out_n` goes low only for a data phase with `xfer_vld`=1, `pri_perr_det`=1 and `pri_resp_en`=1 that is either a downstream write (`txn_kind`≠0, `dir_up`=0) or an upstream read (`txn_kind`=0, `dir_up`=1).
- R8: A qualifying data phase sampled at edge E drives `pri_perr_out_n` low for exactly the one clock that follows edge E+1. Back-to-back qualifying phases give back-to-back low clocks.
- R9: A clock edge with `rst_n`=0 clears both flags, sets `pri_perr_out_n` to 1 and discards any pending parity error drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_vld | input | 1 | A data phase is in progress this cycle |
| txn_kind | input | 2 | 0 read, 1 posted write, 2 delayed write |
| dir_up | input | 1 | 1 upstream (secondary to primary), 0 downstream |
| pri_perr_det | input | 1 | Data parity error detected on the primary bus |
| sec_perr_det | input | 1 | Data parity error detected on the secondary bus |
| pri_perr_in_n | input | 1 | Sampled primary PERR input, active low |
| sec_perr_in_n | input | 1 | Sampled secondary PERR input, active low |
| pri_resp_en | input | 1 | Primary parity error response enable |
| sec_resp_en | input | 1 | Secondary parity error response enable |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 2 | Write-1-to-clear data: bit 0 primary, bit 1 secondary |
| pri_mdpe | output | 1 | Primary master data parity error flag |
| sec_mdpe | output | 1 | Secondary master data parity error flag |
| pri_perr_out_n | output | 1 | Primary parity error drive, active low |

## Verification
The assertions assume that the qualifiers (`xfer_vld`, `txn_kind`, `dir_up` and the enables) are settled before the clock edge where they are sampled, and that `txn_kind` never takes the reserved value 3. The stimulus changes all inputs only on the falling clock edge and draws `txn_kind` from 0 to 2 alone. It also applies the sampled PERR inputs and the detect strobes in the same cycle as the data phase they belong to, because the block treats them as one event.

// File: rtl/bperr_pkg.sv
package bperr_pkg;
  typedef enum logic [1:0] {
    TK_READ   = 2'd0,
    TK_PWRITE = 2'd1,
    TK_DWRITE = 2'd2
  } txn_kind_t;

  localparam int IF_PRI = 0;
  localparam int IF_SEC = 1;
  localparam int NUM_IF = 2;

  // Bridge masters the primary bus on upstream transfers.
  function automatic logic masters_pri(input logic dir_up);
    return dir_up;
  endfunction

  // Bridge masters the secondary bus on downstream transfers.
  function automatic logic masters_sec(input logic dir_up);
    return !dir_up;
  endfunction

  // Bridge receives data on the primary bus: target of a downstream
  // write, or initiator of an upstream read.
  function automatic logic owns_pri_perr(input logic [1:0] kind, input logic dir_up);
    logic is_read;
    is_read = (kind == TK_READ);
    return (dir_up && is_read) || (!dir_up && !is_read);
  endfunction
endpackage

// File: rtl/bperr_set_decode.sv
module bperr_set_decode
  import bperr_pkg::*;
(
  input  logic              xfer_vld,
  input  logic [1:0]        txn_kind,
  input  logic              dir_up,
  input  logic              pri_perr_det,
  input  logic              sec_perr_det,
  input  logic              pri_perr_in_n,
  input  logic              sec_perr_in_n,
  input  logic              pri_resp_en,
  input  logic              sec_resp_en,
  output logic [NUM_IF-1:0] set_vec,
  output logic              perr_evt
);
  logic pri_err_seen;
  logic sec_err_seen;

  always_comb begin
    pri_err_seen     = pri_perr_det || !pri_perr_in_n;
    sec_err_seen     = sec_perr_det || !sec_perr_in_n;
    set_vec[IF_PRI]  = xfer_vld && masters_pri(dir_up) && pri_resp_en && pri_err_seen;
    set_vec[IF_SEC]  = xfer_vld && masters_sec(dir_up) && sec_resp_en && sec_err_seen;
    perr_evt         = xfer_vld && pri_resp_en && pri_perr_det
                       && owns_pri_perr(txn_kind, dir_up);
  end
endmodule

// File: rtl/bperr_sticky.sv
module bperr_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else if (set_vec[i])
        flags[i] <= 1'b1;          // set has priority over clear
      else if (wr && wdata[i])
        flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/bperr_perr_pipe.sv
module bperr_perr_pipe #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic perr_n
);
  logic [LAT-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n)
      stage[0] <= 1'b0;
    else
      stage[0] <= evt;
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)
        stage[i] <= 1'b0;
      else
        stage[i] <= stage[i-1];
    end
  end

  assign perr_n = !stage[LAT-1];
endmodule

// File: rtl/bridge_perr_status.sv
module bridge_perr_status
  import bperr_pkg::*;
#(
  parameter int PERR_LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_vld,
  input  logic [1:0] txn_kind,
  input  logic       dir_up,
  input  logic       pri_perr_det,
  input  logic       sec_perr_det,
  input  logic       pri_perr_in_n,
  input  logic       sec_perr_in_n,
  input  logic       pri_resp_en,
  input  logic       sec_resp_en,
  input  logic       stat_wr,
  input  logic [1:0] stat_wdata,
  output logic       pri_mdpe,
  output logic       sec_mdpe,
  output logic       pri_perr_out_n
);
  logic [NUM_IF-1:0] set_w;
  logic [NUM_IF-1:0] flags_w;
  logic              pri_set_w;
  logic              sec_set_w;
  logic              perr_evt_w;

  bperr_set_decode u_dec (
    .xfer_vld      (xfer_vld),
    .txn_kind      (txn_kind),
    .dir_up        (dir_up),
    .pri_perr_det  (pri_perr_det),
    .sec_perr_det  (sec_perr_det),
    .pri_perr_in_n (pri_perr_in_n),
    .sec_perr_in_n (sec_perr_in_n),
    .pri_resp_en   (pri_resp_en),
    .sec_resp_en   (sec_resp_en),
    .set_vec       (set_w),
    .perr_evt      (perr_evt_w)
  );

  bperr_sticky #(.N(NUM_IF)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_w),
    .wr      (stat_wr),
    .wdata   (stat_wdata),
    .flags   (flags_w)
  );

  bperr_perr_pipe #(.LAT(PERR_LAT)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (perr_evt_w),
    .perr_n (pri_perr_out_n)
  );

  assign pri_set_w = set_w[IF_PRI];
  assign sec_set_w = set_w[IF_SEC];
  assign pri_mdpe  = flags_w[IF_PRI];
  assign sec_mdpe  = flags_w[IF_SEC];
endmodule

// File: rtl/bperr_checker.sv
module bperr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_vld,
  input logic       dir_up,
  input logic       pri_resp_en,
  input logic       sec_resp_en,
  input logic       stat_wr,
  input logic [1:0] stat_wdata,
  input logic       pri_set_w,
  input logic       sec_set_w,
  input logic       perr_evt_w,
  input logic       pri_mdpe,
  input logic       sec_mdpe,
  input logic       pri_perr_out_n
);
  AST_PRI_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pri_mdpe) |-> $past(xfer_vld && dir_up && pri_resp_en)); // R1
  AST_PRI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_resp_en |=> !$rose(pri_mdpe)); // R2
  AST_SEC_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_mdpe) |-> $past(xfer_vld && !dir_up && sec_resp_en)); // R3
  AST_NO_WRONG_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_up |=> !$rose(pri_mdpe)) and (dir_up |=> !$rose(sec_mdpe))); // R4
  AST_PRI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pri_mdpe && !(stat_wr && stat_wdata[0]) |=> pri_mdpe); // R5
  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_mdpe && !(stat_wr && stat_wdata[1]) |=> sec_mdpe); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_set_w |=> pri_mdpe) and (sec_set_w |=> sec_mdpe)); // R6
  AST_PERR_ONLY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_perr_out_n |-> $past(perr_evt_w, 2)); // R7
  AST_PERR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt_w |-> ##2 !pri_perr_out_n); // R8
endmodule

bind bridge_perr_status bperr_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .xfer_vld       (xfer_vld),
  .dir_up         (dir_up),
  .pri_resp_en    (pri_resp_en),
  .sec_resp_en    (sec_resp_en),
  .stat_wr        (stat_wr),
  .stat_wdata     (stat_wdata),
  .pri_set_w      (pri_set_w),
  .sec_set_w      (sec_set_w),
  .perr_evt_w     (perr_evt_w),
  .pri_mdpe       (pri_mdpe),
  .sec_mdpe       (sec_mdpe),
  .pri_perr_out_n (pri_perr_out_n)
);

// File: tb/bridge_perr_status_bench.sv
`timescale 1ns/1ps
module bridge_perr_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_vld = 0, dir_up = 0, pri_perr_det = 0, sec_perr_det = 0;
  logic pri_perr_in_n = 1, sec_perr_in_n = 1, pri_resp_en = 0, sec_resp_en = 0;
  logic stat_wr = 0;
  logic [1:0] txn_kind = 0, stat_wdata = 0;
  logic pri_mdpe, sec_mdpe, pri_perr_out_n;

  int tests = 0, fails = 0;
  string cur_req = "R9";
  bit done = 0;

  always #4 clk = ~clk;

  bridge_perr_status u_bridge_perr_status (
    .clk(clk), .rst_n(rst_n), .xfer_vld(xfer_vld), .txn_kind(txn_kind),
    .dir_up(dir_up), .pri_perr_det(pri_perr_det), .sec_perr_det(sec_perr_det),
    .pri_perr_in_n(pri_perr_in_n), .sec_perr_in_n(sec_perr_in_n),
    .pri_resp_en(pri_resp_en), .sec_resp_en(sec_resp_en),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .pri_mdpe(pri_mdpe), .sec_mdpe(sec_mdpe), .pri_perr_out_n(pri_perr_out_n));

  // Reference model: behavioural, updated on the rising edge.
  int m_pri = 0, m_sec = 0;
  int hist[$];
  int m_perr_n = 1;

  always @(posedge clk) begin
    int p_hit, s_hit, evt, is_wr;
    if (!rst_n) begin
      m_pri = 0; m_sec = 0; hist.delete(); m_perr_n = 1;
    end else begin
      p_hit = (xfer_vld && dir_up == 1 && pri_resp_en && (pri_perr_det || pri_perr_in_n == 0)) ? 1 : 0;
      s_hit = (xfer_vld && dir_up == 0 && sec_resp_en && (sec_perr_det || sec_perr_in_n == 0)) ? 1 : 0;
      if (p_hit) m_pri = 1; else if (stat_wr && stat_wdata[0]) m_pri = 0;
      if (s_hit) m_sec = 1; else if (stat_wr && stat_wdata[1]) m_sec = 0;
      is_wr = (txn_kind != 0) ? 1 : 0;
      evt = 0;
      if (xfer_vld && pri_resp_en && pri_perr_det) begin
        if (dir_up == 0 && is_wr == 1) evt = 1;
        if (dir_up == 1 && is_wr == 0) evt = 1;
      end
      hist.push_back(evt);
      if (hist.size() > 2) void'(hist.pop_front());
      m_perr_n = (hist.size() == 2 && hist[0] == 1) ? 0 : 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "pri_mdpe", int'(pri_mdpe), m_pri);
      check(cur_req, "sec_mdpe", int'(sec_mdpe), m_sec);
      check(cur_req, "pri_perr_out_n", int'(pri_perr_out_n), m_perr_n);
    end
  end

  task automatic idle();
    xfer_vld = 0; pri_perr_det = 0; sec_perr_det = 0;
    pri_perr_in_n = 1; sec_perr_in_n = 1; stat_wr = 0; stat_wdata = 0;
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic phase(bit vld, bit [1:0] kind, bit up, bit pdet, bit sdet,
                       bit pin_n, bit sin_n);
    xfer_vld = vld; txn_kind = kind; dir_up = up; pri_perr_det = pdet;
    sec_perr_det = sdet; pri_perr_in_n = pin_n; sec_perr_in_n = sin_n;
    step(); idle();
  endtask

  task automatic clear_all();
    stat_wr = 1; stat_wdata = 2'b11; step(); idle();
  endtask

  initial begin
    idle();
    step(3);
    cur_req = "R9";
    check("R9", "reset pri_mdpe", int'(pri_mdpe), 0);
    check("R9", "reset perr_n", int'(pri_perr_out_n), 1);
    rst_n = 1;
    step();

    // R1: each kind, each trigger source, upstream
    cur_req = "R1"; pri_resp_en = 1; sec_resp_en = 1;
    for (int k = 0; k < 3; k++) begin
      phase(1, k[1:0], 1, 1, 0, 1, 1);
      check("R1", "det sets pri", int'(pri_mdpe), 1);
      clear_all();
      phase(1, k[1:0], 1, 0, 0, 0, 1);
      check("R1", "perr_in sets pri", int'(pri_mdpe), 1);
      clear_all();
    end
    phase(0, 0, 1, 1, 1, 0, 0);
    check("R1", "no vld no set", int'(pri_mdpe), 0);
    step(2);

    // R2: primary enable gates, secondary enable irrelevant
    cur_req = "R2"; pri_resp_en = 0; sec_resp_en = 1;
    phase(1, 1, 1, 1, 0, 0, 1);
    check("R2", "pri_en=0", int'(pri_mdpe), 0);
    pri_resp_en = 1; sec_resp_en = 0;
    phase(1, 2, 1, 1, 0, 1, 1);
    check("R2", "sec_en=0 pri still sets", int'(pri_mdpe), 1);
    clear_all(); step(2);

    // R3: secondary flag on downstream
    cur_req = "R3"; sec_resp_en = 1; pri_resp_en = 0;
    phase(1, 0, 0, 0, 1, 1, 1);
    check("R3", "sec det sets", int'(sec_mdpe), 1);
    clear_all();
    phase(1, 1, 0, 0, 0, 1, 0);
    check("R3", "sec perr_in sets", int'(sec_mdpe), 1);
    clear_all();
    sec_resp_en = 0; pri_resp_en = 1;
    phase(1, 2, 0, 0, 1, 1, 0);
    check("R3", "sec_en=0", int'(sec_mdpe), 0);
    step(2);

    // R4: wrong-side errors ignored
    cur_req = "R4"; pri_resp_en = 1; sec_resp_en = 1;
    phase(1, 1, 0, 1, 0, 0, 1);
    check("R4", "down pri err", int'(pri_mdpe), 0);
    phase(1, 0, 1, 0, 1, 1, 0);
    check("R4", "up sec err", int'(sec_mdpe), 0);
    step(3);

    // R5: sticky and write-1-to-clear per bit
    cur_req = "R5";
    phase(1, 0, 1, 1, 0, 1, 1);
    phase(1, 0, 0, 0, 1, 1, 1);
    step(3);
    check("R5", "pri held", int'(pri_mdpe), 1);
    stat_wr = 1; stat_wdata = 2'b00; step(); idle();
    check("R5", "wr0 pri", int'(pri_mdpe), 1);
    check("R5", "wr0 sec", int'(sec_mdpe), 1);
    stat_wr = 1; stat_wdata = 2'b10; step(); idle();
    check("R5", "wr bit1 keeps pri", int'(pri_mdpe), 1);
    check("R5", "wr bit1 clears sec", int'(sec_mdpe), 0);
    stat_wr = 1; stat_wdata = 2'b01; step(); idle();
    check("R5", "wr bit0 clears pri", int'(pri_mdpe), 0);

    // R6: set beats clear
    cur_req = "R6";
    stat_wr = 1; stat_wdata = 2'b11;
    phase(1, 1, 1, 1, 0, 1, 1);
    check("R6", "pri set wins", int'(pri_mdpe), 1);
    stat_wr = 1; stat_wdata = 2'b11;
    phase(1, 1, 0, 0, 1, 1, 1);
    check("R6", "sec set wins", int'(sec_mdpe), 1);
    clear_all(); step(2);

    // R7: PERR drive ownership over all kind/direction pairs
    cur_req = "R7";
    for (int k = 0; k < 3; k++) begin
      for (int u = 0; u < 2; u++) begin
        phase(1, k[1:0], u[0], 1, 0, 1, 1);
        step();
        check("R7", "perr drive", int'(pri_perr_out_n),
              ((k == 0) == (u == 1)) ? 0 : 1);
        step(2);
      end
    end
    pri_resp_en = 0;
    phase(1, 1, 0, 1, 0, 1, 1); step();
    check("R7", "perr with pri_en=0", int'(pri_perr_out_n), 1);
    pri_resp_en = 1; clear_all(); step(2);

    // R8: latency and width, back-to-back
    cur_req = "R8";
    phase(1, 2, 0, 1, 0, 1, 1);
    check("R8", "not yet after 1", int'(pri_perr_out_n), 1);
    step();
    check("R8", "low after 2", int'(pri_perr_out_n), 0);
    step();
    check("R8", "released", int'(pri_perr_out_n), 1);
    phase(1, 0, 1, 1, 0, 1, 1);
    phase(1, 0, 1, 1, 0, 1, 1);
    step(3);

    // Mixed stimulus against the model
    cur_req = "R1";
    for (int i = 0; i < 400; i++) begin
      xfer_vld = $urandom_range(0, 1); txn_kind = 2'($urandom_range(0, 2));
      dir_up = $urandom_range(0, 1); pri_perr_det = ($urandom_range(0, 3) == 0);
      sec_perr_det = ($urandom_range(0, 3) == 0); pri_perr_in_n = ($urandom_range(0, 4) != 0);
      sec_perr_in_n = ($urandom_range(0, 4) != 0); pri_resp_en = $urandom_range(0, 1);
      sec_resp_en = $urandom_range(0, 1); stat_wr = ($urandom_range(0, 3) == 0);
      stat_wdata = 2'($urandom_range(0, 3));
      step();
    end

    // R9: mid-run reset drops a pending drive
    cur_req = "R9"; idle(); pri_resp_en = 1; sec_resp_en = 1;
    phase(1, 0, 1, 1, 0, 1, 1);
    rst_n = 0; step(); rst_n = 1;
    check("R9", "pri cleared", int'(pri_mdpe), 0);
    step();
    check("R9", "pending drive dropped", int'(pri_perr_out_n), 1);
    step(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule